// File: doc/BRIEF.md
# Banked Interrupt Enable and Wake Controller

This block gathers 128 level-sensitive interrupt lines into four banks of 32 and exposes them through a small word-addressed register bus. Each source has an enable bit that software turns on through a write-one-to-set word and turns off through a separate write-one-to-clear word. Because the two words are separate, no read-modify-write sequence is needed, and two agents that each touch their own bits never overwrite each other. The raw line levels, masked by the enables, form a pending word per bank and one shared interrupt request. A bit in a control word can gate that request off.

To prepare for a low-power stop, software loads a wake mask per bank and then writes 1 to a holdoff word and reads it back. A read of 0 means an enabled source was already pending, so the request was refused and software must service it and try again. While holdoff is set, any masked source that goes high raises the wake output. The same event drops the holdoff on the next clock edge. Several other words (control, priority mask, synchronizer control and one security word per bank) are plain read/write storage.

Top module: `irq_bank_ctl`

## Requirements
- R1: After reset all enable words, wake mask words, storage words and the holdoff bit read 0, and irq and wake are low.
- R2: A bus write to word 0x100 + 4*b sets every enable bit of bank b whose write-data bit is 1 and leaves the rest unchanged. Source n lives in bank n>>5 at bit n&31.
- R3: A bus write to word 0x180 + 4*b clears every enable bit of bank b whose write-data bit is 1 and leaves the rest unchanged.
- R4: Reading word 0x100 + 4*b or word 0x180 + 4*b returns the enable word of bank b.
- R5: Reading word 0xD00 + 4*b returns (source levels AND enables) of bank b. The result follows the inputs with no latching.
- R6: irq equals bit 0 of the control word (0x00) ANDed with the OR of all pending bits.
- R7: The words 0x00, 0x0C, 0x10, 0x80 + 4*b and 0xE00 + 4*b (the wake masks) read back the last value written to them.
- R8: A write to word 0x14 with data bit 0 equal to 1 sets holdoff only when no enabled source is pending at that clock edge; otherwise holdoff becomes 0. A read of 0x14 returns holdoff in bit 0 and zeros elsewhere.
- R9: Holdoff returns to 0 after a write to 0x14 with data bit 0 equal to 0. It also returns to 0 on the clock edge after wake is high, unless a write to 0x14 takes place on that edge.
- R10: wake equals holdoff ANDed with the OR of (source levels AND wake mask) over all banks, whatever the enables.
- R11: A word outside the map reads 0. This includes bank slots 4 and above and any unaligned address. Writes to such words, and to the pending words, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 12 | Byte address of the accessed word |
| bus_we | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_lvl | input | 128 | Interrupt source levels, bit n is source n |
| irq | output | 1 | Combined interrupt request |
| wake | output | 1 | Wake request while holdoff is armed |

## Verification
The bench drives every one of the 128 sources alone, one after another, and reads all four pending words each time. This catches a source routed to the wrong bank or bit, and shows that the enable bit, not the line level, decides whether irq appears. Overlapping set and clear patterns on one bank show whether zero bits are really left untouched. The holdoff sequence separates the cases of a masked source, an unmasked source and an enabled pending source, which shows that wake follows the wake mask while refusal follows the enables. Writes to unmapped slots and to the pending words are followed by read-back of every word they could have corrupted.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned REGION_LSB = 7;
  localparam int unsigned REGION_W = ADDR_W - REGION_LSB;

  // fixed single words
  localparam logic [ADDR_W-1:0] A_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] A_PMASK = 12'h00C;
  localparam logic [ADDR_W-1:0] A_SYNC  = 12'h010;
  localparam logic [ADDR_W-1:0] A_HOLD  = 12'h014;

  // banked regions, 128 bytes each, selected by the upper address bits
  localparam logic [REGION_W-1:0] RG_SEC   = 5'h01;
  localparam logic [REGION_W-1:0] RG_ENSET = 5'h02;
  localparam logic [REGION_W-1:0] RG_ENCLR = 5'h03;
  localparam logic [REGION_W-1:0] RG_PEND  = 5'h1A;
  localparam logic [REGION_W-1:0] RG_WAKE  = 5'h1C;

  typedef struct packed {
    logic set;
    logic clr;
    logic wmask;
    logic sec;
  } bank_we_t;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank import irqc_pkg::*; #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  bank_we_t     we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q,
  output logic [W-1:0] wmask_q,
  output logic [W-1:0] sec_q
);
  logic [W-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (we.set)      en_d = en_q | wdata;
    else if (we.clr) en_d = en_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      wmask_q <= '0;
      sec_q   <= '0;
    end else begin
      en_q <= en_d;
      if (we.wmask) wmask_q <= wdata;
      if (we.sec)   sec_q   <= wdata;
    end
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we.set |=> (((en_q & $past(wdata)) == $past(wdata)) &&
                ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata)))));

  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we.clr && !we.set) |=> (((en_q & $past(wdata)) == '0) &&
                             ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata)))));

  p_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!we.set && !we.clr) |=> $stable(en_q));
endmodule

// File: rtl/irqc_holdoff.sv
module irqc_holdoff (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_we,
  input  logic hold_wbit,
  input  logic any_pend,
  input  logic wake_hit,
  output logic hold_q,
  output logic wake
);
  logic hold_d;

  assign wake = hold_q && wake_hit;

  always_comb begin
    hold_d = hold_q;
    if (hold_we)   hold_d = hold_wbit && !any_pend;
    else if (wake) hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_we && hold_wbit && any_pend) |=> !hold_q);

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_we && hold_wbit && !any_pend) |=> hold_q);

  p_zero_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_we && !hold_wbit) |=> !hold_q);

  p_wake_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !hold_we) |=> !hold_q);
endmodule

// File: rtl/irq_bank_ctl.sv
module irq_bank_ctl import irqc_pkg::*; #(
  parameter int unsigned NUM_BANKS   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_we,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  input  logic [NUM_BANKS*DATA_W-1:0]   src_lvl,
  output logic                          irq,
  output logic                          wake
);
  localparam int unsigned BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int unsigned SLOT_W = REGION_LSB - 2;

  logic rst_ni;

  irqc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  // address decode
  logic [REGION_W-1:0] region;
  logic [SLOT_W-1:0]   slot;
  logic [BIDX_W-1:0]   slot_idx;
  logic                slot_ok;

  assign region   = bus_addr[ADDR_W-1:REGION_LSB];
  assign slot     = bus_addr[REGION_LSB-1:2];
  assign slot_idx = slot[BIDX_W-1:0];
  assign slot_ok  = (32'(slot) < NUM_BANKS) && (bus_addr[1:0] == 2'b00);

  // per-bank state
  logic [DATA_W-1:0]    en_w   [NUM_BANKS];
  logic [DATA_W-1:0]    wm_w   [NUM_BANKS];
  logic [DATA_W-1:0]    sec_w  [NUM_BANKS];
  logic [DATA_W-1:0]    pend_w [NUM_BANKS];
  logic [NUM_BANKS-1:0] pend_any_v;
  logic [NUM_BANKS-1:0] wake_hit_v;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic     hit;
    bank_we_t bwe;

    assign hit = bus_we && slot_ok && (32'(slot) == b);
    assign bwe = '{set:   hit && (region == RG_ENSET),
                   clr:   hit && (region == RG_ENCLR),
                   wmask: hit && (region == RG_WAKE),
                   sec:   hit && (region == RG_SEC)};

    irqc_bank #(.W(DATA_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_ni),
      .we      (bwe),
      .wdata   (bus_wdata),
      .en_q    (en_w[b]),
      .wmask_q (wm_w[b]),
      .sec_q   (sec_w[b])
    );

    assign pend_w[b]     = src_lvl[b*DATA_W +: DATA_W] & en_w[b];
    assign pend_any_v[b] = |pend_w[b];
    assign wake_hit_v[b] = |(src_lvl[b*DATA_W +: DATA_W] & wm_w[b]);
  end

  // single storage words
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] pmask_q, pmask_d;
  logic [DATA_W-1:0] sync_q, sync_d;

  always_comb begin
    ctrl_d  = ctrl_q;
    pmask_d = pmask_q;
    sync_d  = sync_q;
    if (bus_we) begin
      if (bus_addr == A_CTRL)  ctrl_d  = bus_wdata;
      if (bus_addr == A_PMASK) pmask_d = bus_wdata;
      if (bus_addr == A_SYNC)  sync_d  = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      pmask_q <= '0;
      sync_q  <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      pmask_q <= pmask_d;
      sync_q  <= sync_d;
    end
  end

  // low-power holdoff and wake
  logic hold_q;

  irqc_holdoff u_holdoff (
    .clk       (clk),
    .rst_n     (rst_ni),
    .hold_we   (bus_we && (bus_addr == A_HOLD)),
    .hold_wbit (bus_wdata[0]),
    .any_pend  (|pend_any_v),
    .wake_hit  (|wake_hit_v),
    .hold_q    (hold_q),
    .wake      (wake)
  );

  assign irq = ctrl_q[0] && (|pend_any_v);

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL)       bus_rdata = ctrl_q;
    else if (bus_addr == A_PMASK) bus_rdata = pmask_q;
    else if (bus_addr == A_SYNC)  bus_rdata = sync_q;
    else if (bus_addr == A_HOLD)  bus_rdata = {{(DATA_W-1){1'b0}}, hold_q};
    else if (slot_ok) begin
      case (region)
        RG_SEC:             bus_rdata = sec_w[slot_idx];
        RG_ENSET, RG_ENCLR: bus_rdata = en_w[slot_idx];
        RG_PEND:            bus_rdata = pend_w[slot_idx];
        RG_WAKE:            bus_rdata = wm_w[slot_idx];
        default:            bus_rdata = '0;
      endcase
    end
  end

  p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> (|src_lvl));

  p_wake_src_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    wake |-> (|src_lvl));

  p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    !(bus_we && (bus_addr == A_CTRL)) |=> $stable(ctrl_q));
endmodule

// File: tb/irq_bank_ctl_bench.sv
module irq_bank_ctl_bench;
  localparam int NB = 4;
  localparam int NS = NB * 32;
  localparam logic [11:0] W_CTRL  = 12'h000;
  localparam logic [11:0] W_PMASK = 12'h00C;
  localparam logic [11:0] W_SYNC  = 12'h010;
  localparam logic [11:0] W_HOLD  = 12'h014;
  localparam logic [11:0] W_SEC   = 12'h080;
  localparam logic [11:0] W_SET   = 12'h100;
  localparam logic [11:0] W_CLR   = 12'h180;
  localparam logic [11:0] W_PEND  = 12'hD00;
  localparam logic [11:0] W_WAKE  = 12'hE00;
  localparam logic [11:0] W_NONE  = 12'hFFC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_addr = W_NONE;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NS-1:0] src = '0;
  logic          irq, wake;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_bank_ctl u_irq_bank_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_lvl   (src),
    .irq       (irq),
    .wake      (wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = W_NONE;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rdchk("R1 ctrl", W_CTRL, 32'h0);
    rdchk("R1 pmask", W_PMASK, 32'h0);
    rdchk("R1 sync", W_SYNC, 32'h0);
    rdchk("R1 hold", W_HOLD, 32'h0);
    for (int b = 0; b < NB; b++) begin
      rdchk("R1 enable", W_SET + 12'(4*b), 32'h0);
      rdchk("R1 wakemask", W_WAKE + 12'(4*b), 32'h0);
      rdchk("R1 sec", W_SEC + 12'(4*b), 32'h0);
    end
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 wake", {31'd0, wake}, 32'd0);

    // R7 storage words
    wr(W_CTRL, 32'h8001_0001);  rdchk("R7 ctrl", W_CTRL, 32'h8001_0001);
    wr(W_PMASK, 32'h0000_001F); rdchk("R7 pmask", W_PMASK, 32'h0000_001F);
    wr(W_SYNC, 32'h0000_0002);  rdchk("R7 sync", W_SYNC, 32'h0000_0002);
    for (int b = 0; b < NB; b++) begin
      wr(W_SEC + 12'(4*b), 32'h1234_5670 + 32'(b));
      wr(W_WAKE + 12'(4*b), 32'h0F0F_0000 ^ (32'h1 << (3*b)));
    end
    for (int b = 0; b < NB; b++) begin
      rdchk("R7 sec", W_SEC + 12'(4*b), 32'h1234_5670 + 32'(b));
      rdchk("R7 wakemask", W_WAKE + 12'(4*b), 32'h0F0F_0000 ^ (32'h1 << (3*b)));
    end
    for (int b = 0; b < NB; b++) wr(W_WAKE + 12'(4*b), 32'h0);

    // R2 R5 R6 R3 R4: every source alone
    for (int n = 0; n < NS; n++) begin
      int bk;
      logic [31:0] bw;
      bk = n >> 5;
      bw = 32'h1 << (n & 31);
      src = '0;
      src[n] = 1'b1;
      rdchk("R5 pend before enable", W_PEND + 12'(4*bk), 32'h0);
      chk("R6 irq before enable", {31'd0, irq}, 32'd0);
      wr(W_SET + 12'(4*bk), bw);
      for (int k = 0; k < NB; k++)
        rdchk("R2 R5 pend routing", W_PEND + 12'(4*k), (k == bk) ? bw : 32'h0);
      chk("R6 irq enabled", {31'd0, irq}, 32'd1);
      wr(W_CLR + 12'(4*bk), bw);
      rdchk("R3 R4 enable cleared", W_CLR + 12'(4*bk), 32'h0);
      chk("R6 irq after clear", {31'd0, irq}, 32'd0);
    end
    src = '0;

    // R2 R3 R4 overlapping patterns on bank 2
    wr(W_SET + 12'h8, 32'hA5A5_A5A5);
    wr(W_SET + 12'h8, 32'h0F00_0000);
    acc = 32'hA5A5_A5A5 | 32'h0F00_0000;
    rdchk("R2 set keeps zeros", W_SET + 12'h8, acc);
    wr(W_CLR + 12'h8, 32'h0000_0081);
    acc = acc & ~32'h0000_0081;
    rdchk("R3 clear keeps zeros", W_SET + 12'h8, acc);
    rdchk("R4 read via clear word", W_CLR + 12'h8, acc);
    rdchk("R2 other bank untouched", W_SET + 12'h4, 32'h0);
    wr(W_CLR + 12'h8, 32'hFFFF_FFFF);

    // R6 control gating, R5 level following
    wr(W_SET, 32'h0000_0080);
    src[7] = 1'b1;
    #1 chk("R6 irq with ctrl on", {31'd0, irq}, 32'd1);
    wr(W_CTRL, 32'h8001_0000);
    chk("R6 irq gated by ctrl bit0", {31'd0, irq}, 32'd0);
    rdchk("R5 pend independent of ctrl", W_PEND, 32'h0000_0080);
    wr(W_CTRL, 32'h8001_0001);
    chk("R6 irq back on", {31'd0, irq}, 32'd1);
    src[7] = 1'b0;
    rdchk("R5 pend follows level", W_PEND, 32'h0);
    chk("R6 irq drops with level", {31'd0, irq}, 32'd0);
    wr(W_CLR, 32'hFFFF_FFFF);

    // R8 R9 R10 holdoff and wake
    wr(W_WAKE + 12'h4, 32'h0000_0010);          // source 36
    wr(W_HOLD, 32'h1);
    rdchk("R8 hold accepted", W_HOLD, 32'h1);
    chk("R10 wake idle", {31'd0, wake}, 32'd0);
    src[37] = 1'b1;
    #1 chk("R10 unmasked source no wake", {31'd0, wake}, 32'd0);
    rdchk("R9 hold kept", W_HOLD, 32'h1);
    src[36] = 1'b1;
    #1 chk("R10 masked source wakes", {31'd0, wake}, 32'd1);
    rdchk("R9 hold dropped after wake", W_HOLD, 32'h0);
    chk("R10 wake low after drop", {31'd0, wake}, 32'd0);
    src = '0;
    src[5] = 1'b1;
    wr(W_SET, 32'h0000_0020);
    wr(W_HOLD, 32'h1);
    rdchk("R8 hold refused when pending", W_HOLD, 32'h0);
    wr(W_CLR, 32'h0000_0020);
    wr(W_HOLD, 32'h1);
    rdchk("R8 hold accepted when quiet", W_HOLD, 32'h1);
    wr(W_HOLD, 32'h0);
    rdchk("R9 hold cleared by zero write", W_HOLD, 32'h0);

    // R11 unmapped words and pending writes
    wr(W_SET + 12'h4, 32'h0000_1111);
    wr(12'h200, 32'hFFFF_FFFF);
    wr(12'h090, 32'hFFFF_FFFF);
    wr(12'h110, 32'hFFFF_FFFF);
    wr(12'h102, 32'hFFFF_FFFF);
    wr(W_PEND, 32'hFFFF_FFFF);
    wr(12'hE10, 32'hFFFF_FFFF);
    rdchk("R11 unmapped 0x200", 12'h200, 32'h0);
    rdchk("R11 sec slot4", 12'h090, 32'h0);
    rdchk("R11 enable slot4", 12'h110, 32'h0);
    rdchk("R11 unaligned", 12'h102, 32'h0);
    rdchk("R11 enable bank0 intact", W_SET, 32'h0);
    rdchk("R11 enable bank1 intact", W_SET + 12'h4, 32'h0000_1111);
    rdchk("R11 pend after write", W_PEND, 32'h0);
    for (int b = 0; b < NB; b++)
      rdchk("R11 sec intact", W_SEC + 12'(4*b), 32'h1234_5670 + 32'(b));
    rdchk("R11 wakemask bank0 intact", W_WAKE, 32'h0);
    rdchk("R11 wakemask bank1 intact", W_WAKE + 12'h4, 32'h0000_0010);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule